// File: doc/BRIEF.md
# Load-Use Hazard Detector with Operand Bypass

This block sits at the boundary between register read and execute in a five-stage scalar pipeline. It has 32 registers of 32 bits. Each cycle it looks at the instruction in the read stage and at the instruction one stage ahead. If the instruction ahead is a load whose destination is a source the read-stage instruction actually uses, the block raises a stall. On the next edge it loads a shift-left-logical no-op, with zero flags and an all-zero word, into its execute latch in place of that instruction. The surrounding pipeline holds its fetch and read latches while stall is high. The no-op then moves on as a bubble.

The block also owns the scalar register file. It drives the two execute-stage operands from the register-file entries named by the execute latch. A result that is waiting in the writeback latch takes priority over the stored register value. Register zero always reads as zero. An instruction marked as vector gets zero operands, and no scalar operand path is used for it.

Top module: `ldu_hazard_bypass`

## Requirements
- R1: stall is never high while ahead_load is low, whatever the read-stage instruction is.
- R2: With ahead_load high, stall is high in the same cycle when ahead_dest equals rs (rd_word[25:21]) and rd_flags[0] (needs rs) is set, or when it equals rt (rd_word[20:16]) and rd_flags[1] (needs rt) is set. A match on a source whose need flag is clear does not stall.
- R3: An ahead_dest of zero never causes a stall.
- R4: After a clock edge taken while stall is high, ex_opcode is the no-op id 0, ex_word is 0x00000000 and ex_flags is 0.
- R5: After a clock edge taken while stall is low, ex_opcode, ex_word and ex_flags equal the rd_opcode, rd_word and rd_flags that were present at that edge. The flag bits are: [0] needs rs, [1] needs rt, [2] load, [3] vector.
- R6: op_a is the register named by ex_word[25:21] and op_b is the register named by ex_word[20:16]. A register is written at the clock edge when wb_en is high and wb_dest is nonzero.
- R7: When wb_en is high and wb_dest equals a nonzero source field of ex_word, that operand is wb_value in the same cycle.
- R8: A source field of zero gives an operand of zero, even when wb_en is high with wb_dest zero and wb_value nonzero.
- R9: While ex_flags[3] (vector) is set, op_a and op_b are zero.
- R10: While rst_n is low, stall is low. After a reset edge, the execute latch holds the no-op (opcode 0, word 0, flags 0) and every register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_word | input | 32 | Read-stage instruction word |
| rd_opcode | input | 6 | Read-stage decoded opcode id |
| rd_flags | input | 4 | Read-stage flags: need rs, need rt, load, vector |
| ahead_load | input | 1 | Instruction one stage ahead is a load |
| ahead_dest | input | 5 | Destination register of the instruction ahead |
| wb_en | input | 1 | Writeback latch holds a result |
| wb_dest | input | 5 | Writeback destination register |
| wb_value | input | 32 | Writeback result |
| stall | output | 1 | Load-use hazard this cycle |
| ex_opcode | output | 6 | Execute latch opcode id |
| ex_word | output | 32 | Execute latch instruction word |
| ex_flags | output | 4 | Execute latch flags |
| op_a | output | 32 | Execute operand from rs |
| op_b | output | 32 | Execute operand from rt |

## Verification
The hardest case to reach is a load destination that matches a source field while that source's need flag is clear, and the same case combined with a writeback to that register in the same cycle. With fully random 5-bit fields such collisions are rare. The stimulus therefore draws register fields, the load destination and the writeback destination from a small pool (0 to 3) and sets the need flags at random. This makes matches, flag-gated non-matches, zero destinations and same-cycle bypasses frequent. Directed steps add a zero-destination writeback with a nonzero value and a vector instruction whose sources match the writeback.

// File: rtl/ldu_pkg.sv
// Shared constants for the load-use hazard and bypass block.
// Assumes a 32-bit instruction word with source fields at fixed positions.
package ldu_pkg;
    localparam int RS_LSB   = 21;
    localparam int RT_LSB   = 16;
    localparam int FLG_NRS  = 0;
    localparam int FLG_NRT  = 1;
    localparam int FLG_LOAD = 2;
    localparam int FLG_VEC  = 3;
    localparam int FLW      = 4;
endpackage

// File: rtl/ldu_hazard_detect.sv
// Load-use hazard comparator.
// Compares the load destination of the instruction ahead with the read-stage
// source fields, each gated by its need flag. Purely combinational.
// Assumes register zero is never a real hazard target.
module ldu_hazard_detect #(
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] src_a,
    input  logic [AW-1:0] src_b,
    input  logic          need_a,
    input  logic          need_b,
    input  logic          load_ahead,
    input  logic [AW-1:0] load_dest,
    output logic          hazard
);
    logic hit_a, hit_b;

    // Compare each needed source against the pending load destination.
    always_comb begin
        hit_a  = need_a && (src_a == load_dest);
        hit_b  = need_b && (src_b == load_dest);
        hazard = rst_n && load_ahead && (load_dest != '0) && (hit_a || hit_b);
    end

    assert_stall_only_after_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
        hazard |-> load_ahead);
    assert_no_stall_on_zero_dest_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hazard |-> (load_dest != '0));
    assert_stall_needs_flagged_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hazard |-> (need_a || need_b));
endmodule

// File: rtl/ldu_regfile.sv
// Scalar register file with a bypass from the writeback latch.
// Writes at the clock edge when enabled and the destination is nonzero.
// Read ports are combinational, and the writeback value takes priority over
// the stored value. Address zero always reads as zero.
module ldu_regfile #(
    parameter int XLEN  = 32,
    parameter int NREG  = 32,
    parameter int NPORT = 2,
    localparam int AW   = $clog2(NREG)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [AW-1:0]              wr_addr,
    input  logic [XLEN-1:0]            wr_data,
    input  logic [NPORT-1:0][AW-1:0]   rd_addr,
    output logic [NPORT-1:0][XLEN-1:0] rd_data
);
    logic [XLEN-1:0] mem [NREG];

    // Storage: clear on reset, write nonzero destinations at the edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) mem[i] <= '0;
        end else if (wr_en && wr_addr != '0) begin
            mem[wr_addr] <= wr_data;
        end
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        // Read port: zero register first, then bypass, then storage.
        always_comb begin
            if (rd_addr[p] == '0)
                rd_data[p] = '0;
            else if (wr_en && wr_addr == rd_addr[p])
                rd_data[p] = wr_data;
            else
                rd_data[p] = mem[rd_addr[p]];
        end

        assert_zero_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_addr[p] == '0) |-> (rd_data[p] == '0));
        assert_write_visible_R6: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(wr_en) && $past(wr_addr) != '0 && $past(rst_n) &&
             rd_addr[p] == $past(wr_addr) && !(wr_en && wr_addr == rd_addr[p]))
            |-> (rd_data[p] == $past(wr_data)));
    end
endmodule

// File: rtl/ldu_hazard_bypass.sv
// Top of the load-use hazard and operand bypass block.
// Detects a load-use hazard in the read stage. On a hazard it loads the
// all-zero shift no-op into the execute latch. It supplies the execute
// operands from the register file with writeback bypass. Assumes the
// surrounding pipeline holds fetch/read while stall is high.
module ldu_hazard_bypass #(
    parameter int XLEN   = 32,
    parameter int NREG   = 32,
    parameter int OPW    = 6,
    parameter int NOP_ID = 0,
    localparam int AW    = $clog2(NREG),
    localparam int FLW   = ldu_pkg::FLW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [XLEN-1:0] rd_word,
    input  logic [OPW-1:0]  rd_opcode,
    input  logic [FLW-1:0]  rd_flags,
    input  logic            ahead_load,
    input  logic [AW-1:0]   ahead_dest,
    input  logic            wb_en,
    input  logic [AW-1:0]   wb_dest,
    input  logic [XLEN-1:0] wb_value,
    output logic            stall,
    output logic [OPW-1:0]  ex_opcode,
    output logic [XLEN-1:0] ex_word,
    output logic [FLW-1:0]  ex_flags,
    output logic [XLEN-1:0] op_a,
    output logic [XLEN-1:0] op_b
);
    import ldu_pkg::*;

    localparam logic [OPW-1:0] KILL_OP = OPW'(NOP_ID);

    logic                      hazard;
    logic [1:0][AW-1:0]        src_addr;
    logic [1:0][XLEN-1:0]      src_data;

    ldu_hazard_detect #(.AW(AW)) u_detect (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_a      (rd_word[RS_LSB +: AW]),
        .src_b      (rd_word[RT_LSB +: AW]),
        .need_a     (rd_flags[FLG_NRS]),
        .need_b     (rd_flags[FLG_NRT]),
        .load_ahead (ahead_load),
        .load_dest  (ahead_dest),
        .hazard     (hazard)
    );

    assign stall = hazard;

    // Execute latch: the no-op on reset or hazard, otherwise the read slot.
    always_ff @(posedge clk) begin
        if (!rst_n || hazard) begin
            ex_opcode <= KILL_OP;
            ex_word   <= '0;
            ex_flags  <= '0;
        end else begin
            ex_opcode <= rd_opcode;
            ex_word   <= rd_word;
            ex_flags  <= rd_flags;
        end
    end

    // Operand addresses come from the execute latch fields.
    always_comb begin
        src_addr[0] = ex_word[RS_LSB +: AW];
        src_addr[1] = ex_word[RT_LSB +: AW];
    end

    ldu_regfile #(.XLEN(XLEN), .NREG(NREG), .NPORT(2)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wb_en),
        .wr_addr (wb_dest),
        .wr_data (wb_value),
        .rd_addr (src_addr),
        .rd_data (src_data)
    );

    // Vector instructions get no scalar operands.
    always_comb begin
        op_a = ex_flags[FLG_VEC] ? '0 : src_data[0];
        op_b = ex_flags[FLG_VEC] ? '0 : src_data[1];
    end

    assert_kill_inserts_nop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (ex_word == '0 && ex_opcode == KILL_OP && ex_flags == '0));
    assert_slot_passes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !stall |=> (ex_word == $past(rd_word) && ex_flags == $past(rd_flags)));
    assert_vector_no_operands_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ex_flags[FLG_VEC] |-> (op_a == '0 && op_b == '0));
    assert_reset_clears_latch_R10: assert property (@(posedge clk)
        !rst_n |=> (ex_word == '0 && ex_opcode == KILL_OP));
endmodule

// File: tb/ldu_hazard_bypass_tb_top.sv
module ldu_hazard_bypass_tb_top;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [31:0] rd_word = 0;
    logic [5:0]  rd_opcode = 0;
    logic [3:0]  rd_flags = 0;
    logic        ahead_load = 0;
    logic [4:0]  ahead_dest = 0;
    logic        wb_en = 0;
    logic [4:0]  wb_dest = 0;
    logic [31:0] wb_value = 0;
    logic        stall;
    logic [5:0]  ex_opcode;
    logic [31:0] ex_word;
    logic [3:0]  ex_flags;
    logic [31:0] op_a, op_b;

    int n_cmp = 0, n_bad = 0;
    logic [31:0] m_regs [32];
    logic [5:0]  m_op;
    logic [31:0] m_word;
    logic [3:0]  m_flags;
    logic        m_prev_stall;

    always #10 clk = ~clk;

    ldu_hazard_bypass dut_i (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic exp_hazard(input logic [31:0] w, input logic [3:0] f,
                                        input logic ld, input logic [4:0] d);
        return ld && d != 0 && ((f[0] && w[25:21] == d) || (f[1] && w[20:16] == d));
    endfunction

    function automatic logic [31:0] exp_operand(input logic [4:0] a);
        if (m_flags[3]) return 0;
        if (a == 0) return 0;
        if (wb_en && wb_dest == a) return wb_value;
        return m_regs[a];
    endfunction

    function automatic string opnd_tag(input logic [4:0] a);
        if (m_flags[3]) return "R9";
        if (a == 0) return "R8";
        if (wb_en && wb_dest == a) return "R7";
        return "R6";
    endfunction

    // One cycle: drive at negedge, check after settling, advance the model at posedge.
    task automatic step(input logic [31:0] w, input logic [5:0] op, input logic [3:0] f,
                        input logic ld, input logic [4:0] d,
                        input logic we, input logic [4:0] wd, input logic [31:0] wv);
        logic h;
        @(negedge clk);
        rd_word = w; rd_opcode = op; rd_flags = f;
        ahead_load = ld; ahead_dest = d;
        wb_en = we; wb_dest = wd; wb_value = wv;
        #1;
        h = exp_hazard(w, f, ld, d);
        chk(!ld ? "R1" : (d == 0 ? "R3" : "R2"), 32'(stall), 32'(h));
        chk(m_prev_stall ? "R4" : "R5", ex_word, m_word);
        chk(m_prev_stall ? "R4" : "R5", {22'd0, m_op, m_flags}, {22'd0, ex_opcode, ex_flags});
        chk(opnd_tag(m_word[25:21]), op_a, exp_operand(m_word[25:21]));
        chk(opnd_tag(m_word[20:16]), op_b, exp_operand(m_word[20:16]));
        @(posedge clk);
        if (we && wd != 0) m_regs[wd] = wv;
        m_prev_stall = h;
        if (h) begin m_op = 0; m_word = 0; m_flags = 0; end
        else begin m_op = op; m_word = w; m_flags = f; end
    endtask

    function automatic logic [31:0] mkword(input logic [4:0] rs, input logic [4:0] rt,
                                           input logic [31:0] r);
        return {r[31:26], rs, rt, r[15:0]};
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 32; i++) m_regs[i] = 0;
        m_op = 0; m_word = 0; m_flags = 0; m_prev_stall = 0;
        // Reset with a hazard pattern on the inputs: stall must stay low (R10).
        rd_word = mkword(5'd2, 5'd3, 0); rd_flags = 4'b0011; ahead_load = 1; ahead_dest = 5'd2;
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        chk("R10", 32'(stall), 0);
        chk("R10", ex_word, 0);
        chk("R10", {26'd0, ex_opcode}, 0);
        rst_n = 1;
        // Directed: zero-destination writeback with nonzero value (R8).
        step(mkword(5'd0, 5'd0, 0), 6'd5, 4'b0011, 0, 0, 1, 5'd0, 32'hDEADBEEF);
        step(mkword(5'd0, 5'd0, 0), 6'd5, 4'b0011, 0, 0, 1, 5'd0, 32'hDEADBEEF);
        // Directed: fill r1, then a need-flag-gated non-hazard (R2).
        step(mkword(5'd1, 5'd1, 0), 6'd7, 4'b0000, 1, 5'd1, 1, 5'd1, 32'h1111_0001);
        step(mkword(5'd1, 5'd1, 0), 6'd7, 4'b0010, 1, 5'd2, 0, 0, 0);
        // Directed: hazard via rt, then the bubble (R2, R4).
        step(mkword(5'd3, 5'd2, 0), 6'd9, 4'b0010, 1, 5'd2, 0, 0, 0);
        step(mkword(5'd3, 5'd2, 0), 6'd9, 4'b0010, 0, 5'd2, 0, 0, 0);
        // Directed: vector with sources matching the writeback (R9).
        step(mkword(5'd1, 5'd1, 0), 6'd12, 4'b1011, 0, 0, 1, 5'd1, 32'h5555_AAAA);
        step(mkword(5'd1, 5'd1, 0), 6'd12, 4'b0011, 0, 0, 1, 5'd1, 32'h7777_0000);
        // Random mix with a narrow register pool.
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r;
            logic [3:0]  f;
            r = $urandom;
            f = 4'($urandom);
            f[3] = ($urandom % 8) == 0;
            step(mkword(5'($urandom % 4), 5'($urandom % 4), r), 6'($urandom), f,
                 1'($urandom), 5'($urandom % 4), 1'($urandom),
                 5'($urandom % 4), $urandom);
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule